// File: doc/BRIEF.md
# Power-Gating Interval Controller

This sequencer drives an active-low enable that switches power to an external controller. A free-running millisecond tick enable paces every count. The interval length arrives in ticks from a separate configuration stage, and a flag from that stage marks when the value is settled. With the mode level high, a drive window opens at the start of every interval. With it low, one window opens after configuration and then the block waits for the operator. Each window closes on the first acknowledge edge from the powered controller. If no edge arrives, the window closes a fixed guard band before the interval ends, so the controller is always off for that guard band.

A separate detector debounces the manual push-button and presents it as a qualified level. A qualifying rise while the drive is inactive takes the output low at once. It clears the counters and holds them at zero for as long as the level stays high, and the interval restarts on release. A long press therefore gives a window longer than the programmed one. A press while the drive is already low changes nothing.

Top module: `pgate_seq`

## Requirements
- R1: The mode level selects the behaviour: `periodic_mode` = 1 repeats a window every interval; `periodic_mode` = 0 gives one window after configuration and no further window without a manual trigger.
- R2: `drv_n` is 1 while `rst_n` is 0 and stays 1 while `cfg_done` is 0 (`cfg_done` rises once after reset and stays high); the first window opens on the clock after `cfg_done` is seen high.
- R3: In periodic operation, successive falling edges of `drv_n` are exactly `interval_ticks` ticks apart (when `interval_ticks` exceeds the guard band).
- R4: Without an acknowledge, `drv_n` stays low for `interval_ticks − GUARD_TICKS` ticks and is high for the last `GUARD_TICKS` ticks of the interval.
- R5: A low-to-high edge on `ack_in` during a window sets `drv_n` high no later than four clock cycles after the edge. Any high pulse of two or more clock cycles is caught, which covers a 100 ns pulse at 200 MHz.
- R6: Only the first acknowledge edge of an interval takes effect; edges while `drv_n` is high are dropped and do not shorten the next window.
- R7: In single-shot operation, each window started by a manual trigger has the same length and acknowledge rules as the first.
- R8: A rise of `man_hold` while `drv_n` is low has no effect: the window ends and the next one starts as if it had not occurred.
- R9: A rise of `man_hold` while `drv_n` is high pulls `drv_n` low on the next clock. The counters are held at zero while `man_hold` stays high. On release a full window and interval start afresh, so the next periodic window falls the hold time plus one interval later.
- R10: Acknowledge edges have no effect while `man_hold` is high.
- R11: When `interval_ticks` ≤ `GUARD_TICKS`, the window is one tick long and the interval is `max(interval_ticks, 2)` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per millisecond; all timing counts advance on it |
| interval_ticks | input | IW | Programmed interval length in ticks |
| cfg_done | input | 1 | Interval value is valid; enables operation |
| periodic_mode | input | 1 | 1 = repeating windows, 0 = single window plus manual |
| ack_in | input | 1 | Asynchronous acknowledge from the powered controller |
| man_hold | input | 1 | Debounced, qualified manual power-on level |
| drv_n | output | 1 | Active-low power-switch enable |

## Verification
The bench builds the block with an 8-bit interval, a guard band of 4 ticks and two synchronizer stages, and it pulses the tick every 40 clocks. The small guard band puts the clamp case (interval 3) and whole multi-window periodic runs within a few thousand cycles. The 40-clock tick spacing lets a 100 ns acknowledge pulse rise and fall between two ticks, so the expected window length in ticks is exact.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ON    = 3'd1,
      ST_OFF   = 3'd2,
      ST_HOLD  = 3'd3,
      ST_SPENT = 3'd4
   } pg_state_e;
endpackage

// File: rtl/pgate_ack_sync.sv
module pgate_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_async,
   output logic ack_rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= ack_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign ack_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pgate_window_calc.sv
module pgate_window_calc #(
   parameter int IW          = 16,
   parameter int GUARD_TICKS = 50,
   localparam int CW         = IW + 1
) (
   input  logic [IW-1:0] interval_ticks,
   output logic [CW-1:0] on_len,
   output logic [CW-1:0] period_len
);
   localparam logic [CW-1:0] GUARD_W = CW'(GUARD_TICKS);
   localparam logic [CW-1:0] ONE_W   = CW'(1);

   logic [CW-1:0] intv_w;
   assign intv_w = CW'(interval_ticks);

   generate
      if (GUARD_TICKS == 0) begin : g_no_guard
         assign on_len = (intv_w == '0) ? ONE_W : intv_w;
      end else begin : g_guard
         assign on_len = (intv_w > GUARD_W) ? (intv_w - GUARD_W) : ONE_W;
      end
   endgenerate

   assign period_len = (intv_w > on_len) ? intv_w : (on_len + ONE_W);
endmodule

// File: rtl/pgate_tick_ctr.sv
module pgate_tick_ctr #(
   parameter int CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (adv) count <= count + CW'(1);
   end
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
   import pgate_pkg::*;
#(
   parameter int IW          = 16,
   parameter int GUARD_TICKS = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic [IW-1:0] interval_ticks,
   input  logic          cfg_done,
   input  logic          periodic_mode,
   input  logic          ack_in,
   input  logic          man_hold,
   output logic          drv_n
);
   localparam int CW = IW + 1;

   generate
      if (IW < 2) begin : g_bad_width
         $error("pgate_seq: IW must be at least 2");
      end
      if (GUARD_TICKS < 0 || GUARD_TICKS >= (2 ** IW)) begin : g_bad_guard
         $error("pgate_seq: GUARD_TICKS must fit in IW bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pgate_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pg_state_e     state_q, state_d;
   logic          man_prev_q;
   logic          man_rise;
   logic          ack_rise;
   logic          cnt_clr, cnt_adv;
   logic [CW-1:0] cnt_q, cnt_inc;
   logic [CW-1:0] on_len, period_len;

   pgate_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_async (ack_in),
      .ack_rise  (ack_rise)
   );

   pgate_window_calc #(.IW(IW), .GUARD_TICKS(GUARD_TICKS)) u_calc (
      .interval_ticks (interval_ticks),
      .on_len         (on_len),
      .period_len     (period_len)
   );

   pgate_tick_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .adv   (cnt_adv),
      .count (cnt_q)
   );

   assign cnt_inc  = cnt_q + CW'(1);
   assign man_rise = man_hold & ~man_prev_q;

   always_comb begin
      state_d = state_q;
      cnt_clr = 1'b0;
      cnt_adv = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cfg_done) begin
               cnt_clr = 1'b1;
               state_d = man_rise ? ST_HOLD : ST_ON;
            end
         end
         ST_ON: begin
            cnt_adv = tick_en;
            if (tick_en && (cnt_inc >= on_len))   state_d = ST_OFF;
            else if (ack_rise && !man_hold)       state_d = ST_OFF;
         end
         ST_OFF: begin
            if (man_rise) begin
               cnt_clr = 1'b1;
               state_d = ST_HOLD;
            end else if (tick_en && (cnt_inc >= period_len)) begin
               cnt_clr = 1'b1;
               state_d = periodic_mode ? ST_ON : ST_SPENT;
            end else begin
               cnt_adv = tick_en;
            end
         end
         ST_SPENT: begin
            if (man_rise) begin
               cnt_clr = 1'b1;
               state_d = ST_HOLD;
            end
         end
         ST_HOLD: begin
            cnt_clr = 1'b1;
            if (!man_hold) state_d = ST_ON;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         man_prev_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         man_prev_q <= man_hold;
      end
   end

   assign drv_n = !((state_q == ST_ON) || (state_q == ST_HOLD));
endmodule

// File: rtl/pgate_seq_chk.sv
module pgate_seq_chk
   import pgate_pkg::*;
#(
   parameter int IW          = 16,
   parameter int GUARD_TICKS = 50
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic [IW-1:0] interval_ticks,
   input logic          cfg_done,
   input logic          man_hold,
   input logic          drv_n,
   input logic          ack_rise,
   input pg_state_e     state_q
);
   localparam int CW = IW + 1;

   logic [CW-1:0] low_ticks;
   logic [CW-1:0] lim;

   assign lim = (CW'(interval_ticks) > CW'(GUARD_TICKS))
                ? (CW'(interval_ticks) - CW'(GUARD_TICKS)) : CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_ticks <= '0;
      else if (drv_n || man_hold) low_ticks <= '0;
      else if (tick_en)           low_ticks <= low_ticks + CW'(1);
   end

   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> drv_n);

   a_r4_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_n |-> (low_ticks <= lim));

   a_r5_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && !man_hold && state_q == ST_ON) |=> drv_n);

   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(man_hold) && state_q == ST_ON) |=> (state_q != ST_HOLD));

   a_r9_manual_grab: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(man_hold) && drv_n && cfg_done) |=> !drv_n);

   a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && man_hold) |=> !drv_n);

   a_r10_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && man_hold && !drv_n && !tick_en) |=> !drv_n);
endmodule

bind pgate_seq pgate_seq_chk #(.IW(IW), .GUARD_TICKS(GUARD_TICKS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tick_en        (tick_en),
   .interval_ticks (interval_ticks),
   .cfg_done       (cfg_done),
   .man_hold       (man_hold),
   .drv_n          (drv_n),
   .ack_rise       (ack_rise),
   .state_q        (state_q)
);

// File: tb/pgate_seq_test.sv
`timescale 1ns/1ps
module pgate_seq_test;
   localparam int IW       = 8;
   localparam int GUARD    = 4;
   localparam int TICK_GAP = 40;

   typedef struct {
      int    low;
      int    gap;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic [IW-1:0] interval_ticks = 8'd10;
   logic          cfg_done = 1'b0;
   logic          periodic_mode = 1'b1;
   logic          ack_in = 1'b0;
   logic          man_hold = 1'b0;
   logic          drv_n;

   int   checks = 0;
   int   fails  = 0;
   int   falls  = 0;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   pgate_seq #(.IW(IW), .GUARD_TICKS(GUARD), .SYNC_STAGES(2)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_en        (tick_en),
      .interval_ticks (interval_ticks),
      .cfg_done       (cfg_done),
      .periodic_mode  (periodic_mode),
      .ack_in         (ack_in),
      .man_hold       (man_hold),
      .drv_n          (drv_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_ticks(input int n);
      int seen = 0;
      while (seen < n) begin
         step();
         if (tick_en) seen++;
      end
   endtask

   task automatic wait_fall();
      logic p;
      do begin
         p = drv_n;
         step();
      end while (!(p && !drv_n));
   endtask

   task automatic wait_rise();
      logic p;
      do begin
         p = drv_n;
         step();
      end while (!(!p && drv_n));
   endtask

   task automatic ack_pulse(input bit expect_high, input string tag);
      ack_in = 1'b1;
      repeat (5) step();
      chk(drv_n == expect_high, tag, int'(drv_n), int'(expect_high));
      repeat (15) step();
      ack_in = 1'b0;
      step();
   endtask

   task automatic push(input int low, input int gap, input string tag);
      exp_t e;
      e.low = low;
      e.gap = gap;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_reset(input bit mode, input int intv);
      rst_n = 1'b0;
      cfg_done = 1'b0;
      ack_in = 1'b0;
      man_hold = 1'b0;
      periodic_mode = mode;
      interval_ticks = IW'(intv);
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   // tick generator: one-cycle pulse every TICK_GAP clocks
   initial begin
      forever begin
         repeat (TICK_GAP - 1) @(negedge clk);
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
      end
   end

   // monitor: measures each low window and compares with the scoreboard
   initial begin
      logic prev_drv;
      int   tick_total;
      int   last_fall;
      int   low_cnt;
      bit   active;
      exp_t cur;
      prev_drv = 1'b1;
      tick_total = 0;
      last_fall = -1;
      low_cnt = 0;
      active = 1'b0;
      cur.low = 0;
      cur.gap = -1;
      cur.tag = "";
      forever begin
         step();
         if (!rst_n) begin
            prev_drv = 1'b1;
            last_fall = -1;
            low_cnt = 0;
            active = 1'b0;
         end else begin
            if (prev_drv && !drv_n) begin
               falls++;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R1 R7 unexpected window", falls, 0);
                  active = 1'b0;
               end else begin
                  cur = exp_q.pop_front();
                  active = 1'b1;
                  if (cur.gap >= 0)
                     chk(tick_total - last_fall == cur.gap, "R3 interval between windows",
                         tick_total - last_fall, cur.gap);
               end
               last_fall = tick_total;
               low_cnt = 0;
            end
            if (!prev_drv && drv_n && active) begin
               chk(low_cnt == cur.low, cur.tag, low_cnt, cur.low);
               active = 1'b0;
            end
            if (tick_en) begin
               tick_total++;
               if (!drv_n) low_cnt++;
            end
            prev_drv = drv_n;
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int f0;
      // R2: reset and pre-configuration idle state
      repeat (3) step();
      chk(drv_n == 1'b1, "R2 drive high in reset", int'(drv_n), 1);
      rst_n = 1'b1;
      wait_ticks(5);
      chk(drv_n == 1'b1, "R2 drive high before cfg_done", int'(drv_n), 1);
      chk(falls == 0, "R2 no window before cfg_done", falls, 0);

      // periodic, interval 10: window 6, interval 10
      push(6, -1, "R4 first window length");
      push(6, 10, "R4 unacked window length");
      push(2, 10, "R5 ack shortens window");
      push(6, 10, "R6 late ack ignored");
      push(0, 10, "R5 ack at window start");
      push(9, -1, "R9 R10 manual hold window");
      push(6, 13, "R8 manual while low ignored");
      push(6, 10, "R8 R1 periodic continues");
      cfg_done = 1'b1;
      wait_fall();
      wait_fall();
      wait_fall();
      wait_ticks(2);
      ack_pulse(1'b1, "R5 drive high after ack");
      repeat (5) step();
      ack_pulse(1'b1, "R6 second ack while high");
      wait_fall();
      wait_rise();
      wait_fall();
      ack_pulse(1'b1, "R5 drive high after early ack");
      wait_ticks(2);
      man_hold = 1'b1;
      wait_ticks(1);
      ack_pulse(1'b0, "R10 ack during hold ignored");
      wait_ticks(2);
      man_hold = 1'b0;
      wait_fall();
      wait_ticks(1);
      man_hold = 1'b1;
      wait_ticks(1);
      ack_pulse(1'b0, "R10 ack with manual high ignored");
      wait_ticks(1);
      man_hold = 1'b0;
      wait_fall();
      wait_rise();
      chk(exp_q.size() == 0, "R3 all periodic windows seen", exp_q.size(), 0);

      // clamp: interval 3 is below the guard band
      do_reset(1'b1, 3);
      exp_q.delete();
      push(1, -1, "R11 clamped window");
      push(1, 3, "R11 clamped window");
      push(1, 3, "R11 clamped window");
      cfg_done = 1'b1;
      wait_fall();
      wait_fall();
      wait_fall();
      wait_rise();
      chk(exp_q.size() == 0, "R11 clamped windows seen", exp_q.size(), 0);

      // single-shot, interval 8: window 4
      do_reset(1'b0, 8);
      exp_q.delete();
      push(4, -1, "R7 single window length");
      cfg_done = 1'b1;
      wait_fall();
      wait_rise();
      f0 = falls;
      wait_ticks(20);
      chk(falls == f0, "R1 R7 no repeat in single-shot", falls, f0);
      push(6, -1, "R9 manual window after hold");
      step();
      man_hold = 1'b1;
      wait_ticks(2);
      man_hold = 1'b0;
      wait_rise();
      f0 = falls;
      wait_ticks(12);
      chk(falls == f0, "R7 no repeat after manual window", falls, f0);
      push(2, -1, "R7 manual window closed by ack");
      man_hold = 1'b1;
      wait_ticks(1);
      man_hold = 1'b0;
      wait_ticks(1);
      ack_pulse(1'b1, "R7 ack in manual window");
      f0 = falls;
      wait_ticks(12);
      chk(falls == f0, "R7 stays off after acked window", falls, f0);
      chk(exp_q.size() == 0, "R7 single-shot windows seen", exp_q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule